// File: doc/BRIEF.md
# Dual-Port Semaphore Flag Unit

This block holds a small bank of binary ownership flags that two independent ports, called left and right, share. Either port selects the flag space with its own semaphore enable, which is separate from any memory enable, and a flag address. A port asks for a flag by writing, and gives it back by writing again. To find out whether it now holds the flag, the port reads the flag back. The read returns all zeros when the reading port is the owner and all ones when it is not.

The unit arbitrates only. It never locks memory or anything else in hardware. Software checks the read-back value before it touches the shared resource that the flag stands for. The unit keeps a request that arrives while the other side owns the flag, and it grants that request by itself when the owner releases. Two requests for a free flag in the same cycle never both succeed, and the left port wins that tie.

Top module: `sem_flag_unit`

## Requirements
- R1: After reset every flag is free, no request is pending, and both read-data outputs show all ones.
- R2: No flag is ever owned by both ports at the same time.
- R3: A write with data bit 0 equal to 0 to a free flag grants that flag to the writing port. A later read of it by that port returns all zeros.
- R4: A read of a flag the reading port does not own returns all ones, whether the flag is free or held by the other port.
- R5: When both ports write bit 0 as 0 to the same free flag in the same cycle, the left port gets it and the right port's request stays pending.
- R6: A request made while the other port owns the flag is remembered. It is granted when the owner writes bit 0 as 1, with no further action by the requester.
- R7: A write with bit 0 equal to 1 releases the flag only if the writer owns it. A non-owner that writes 1 leaves the owner unchanged and cancels its own pending request for that flag.
- R8: While a port's semaphore enable is low, its writes and reads have no effect, and its read data holds its last value.
- R9: Flags are independent: an access to one flag address changes no other flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lSemEn | input | 1 | Left port semaphore enable |
| lWrEn | input | 1 | Left port write (1) or read (0) |
| lWrBit | input | 1 | Left port data bit 0: 0 requests, 1 releases |
| lAddr | input | 3 | Left port flag address |
| lRdData | output | 16 | Left port read data, all zeros when left owns the flag |
| rSemEn | input | 1 | Right port semaphore enable |
| rWrEn | input | 1 | Right port write (1) or read (0) |
| rWrBit | input | 1 | Right port data bit 0: 0 requests, 1 releases |
| rAddr | input | 3 | Right port flag address |
| rRdData | output | 16 | Right port read data, all zeros when right owns the flag |

## Verification
A write presented in cycle k changes ownership at the clock edge that ends cycle k. A read presented in cycle k+1 captures that ownership and shows it on the read-data output just after the edge that ends cycle k+1. The bench drives inputs away from the edge and samples outputs one nanosecond after a rising edge. It always issues a read in the cycle after the write under test, so every compare falls one edge after the read request. For the hold case in R8, the bench checks read data after an edge at which the enable was low.

// File: rtl/sem_pkg.sv
package sem_pkg;
  // Per-port decoded strobes handed from control to datapath
  typedef struct packed {
    logic req;   // write with bit 0 = 0
    logic rel;   // write with bit 0 = 1
    logic rd;    // read
  } semStrobe_t;

  localparam int PORT_L = 0;
  localparam int PORT_R = 1;
endpackage

// File: rtl/sem_ctrl.sv
module sem_ctrl
  import sem_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       semEn,
  input  logic [1:0]       wrEn,
  input  logic [1:0]       wrBit,
  output semStrobe_t [1:0] strobe
);
  for (genvar p = 0; p < 2; p++) begin : g_port
    always_comb begin
      strobe[p].req = semEn[p] &  wrEn[p] & ~wrBit[p];
      strobe[p].rel = semEn[p] &  wrEn[p] &  wrBit[p];
      strobe[p].rd  = semEn[p] & ~wrEn[p];
    end

    // R8
    idle_no_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
      !semEn[p] |-> (strobe[p] == '0));
    // R8
    strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
      $onehot0(strobe[p]));
  end
endmodule

// File: rtl/sem_flags.sv
module sem_flags
  import sem_pkg::*;
#(
  parameter int NFLAG = 8,
  parameter int AW    = $clog2(NFLAG),
  parameter int DW    = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  semStrobe_t [1:0]     strobe,
  input  logic [1:0][AW-1:0]   addr,
  output logic [1:0][DW-1:0]   rdData
);
  logic [1:0][NFLAG-1:0] own, pend;
  logic [1:0][NFLAG-1:0] ownNext, pendNext;

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    logic hitL, hitR, reqL, reqR, relL, relR;
    logic heldL, heldR, wantL, wantR, grantL, grantR;

    always_comb begin
      hitL   = (addr[PORT_L] == AW'(i));
      hitR   = (addr[PORT_R] == AW'(i));
      reqL   = strobe[PORT_L].req & hitL;
      reqR   = strobe[PORT_R].req & hitR;
      relL   = strobe[PORT_L].rel & hitL;
      relR   = strobe[PORT_R].rel & hitR;
      heldL  = own[PORT_L][i] & ~relL;
      heldR  = own[PORT_R][i] & ~relR;
      wantL  = (pend[PORT_L][i] | reqL) & ~relL;
      wantR  = (pend[PORT_R][i] | reqR) & ~relR;
      grantL = ~heldL & ~heldR & wantL;
      grantR = ~heldL & ~heldR & ~wantL & wantR;
      ownNext[PORT_L][i]  = heldL | grantL;
      ownNext[PORT_R][i]  = heldR | grantR;
      pendNext[PORT_L][i] = wantL & ~(heldL | grantL);
      pendNext[PORT_R][i] = wantR & ~(heldR | grantR);
    end

    // R2
    no_double_own_chk: assert property (@(posedge clk) disable iff (!rstN)
      !(own[PORT_L][i] && own[PORT_R][i]));
    // R5
    tie_left_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
      (own[PORT_L][i] == 1'b0 && own[PORT_R][i] == 1'b0 &&
       pend[PORT_L][i] == 1'b0 && pend[PORT_R][i] == 1'b0 && reqL && reqR)
      |=> (own[PORT_L][i] && pend[PORT_R][i]));
    // R6
    handoff_chk: assert property (@(posedge clk) disable iff (!rstN)
      (own[PORT_L][i] && relL && pend[PORT_R][i] && !relR) |=> own[PORT_R][i]);
    // R7
    foreign_release_chk: assert property (@(posedge clk) disable iff (!rstN)
      (own[PORT_R][i] && relL && !relR) |=> own[PORT_R][i]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      own  <= '0;
      pend <= '0;
    end else begin
      own  <= ownNext;
      pend <= pendNext;
    end
  end

  for (genvar p = 0; p < 2; p++) begin : g_rd
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)             rdData[p] <= '1;
      else if (strobe[p].rd) rdData[p] <= own[p][addr[p]] ? '0 : '1;
    end

    // R8
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      !strobe[p].rd |=> $stable(rdData[p]));
    // R3
    rd_owned_chk: assert property (@(posedge clk) disable iff (!rstN)
      (strobe[p].rd && own[p][addr[p]]) |=> (rdData[p] == '0));
  end
endmodule

// File: rtl/sem_flag_unit.sv
module sem_flag_unit
  import sem_pkg::*;
#(
  parameter int NFLAG = 8,
  parameter int AW    = $clog2(NFLAG),
  parameter int DW    = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          lSemEn,
  input  logic          lWrEn,
  input  logic          lWrBit,
  input  logic [AW-1:0] lAddr,
  output logic [DW-1:0] lRdData,
  input  logic          rSemEn,
  input  logic          rWrEn,
  input  logic          rWrBit,
  input  logic [AW-1:0] rAddr,
  output logic [DW-1:0] rRdData
);
  semStrobe_t [1:0]     strobe;
  logic [1:0][DW-1:0]   rdData;
  logic [1:0][AW-1:0]   addr;

  assign addr    = {rAddr, lAddr};
  assign lRdData = rdData[PORT_L];
  assign rRdData = rdData[PORT_R];

  sem_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .semEn  ({rSemEn, lSemEn}),
    .wrEn   ({rWrEn, lWrEn}),
    .wrBit  ({rWrBit, lWrBit}),
    .strobe (strobe)
  );

  sem_flags #(.NFLAG(NFLAG), .AW(AW), .DW(DW)) u_flags (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .addr   (addr),
    .rdData (rdData)
  );
endmodule

// File: tb/sim_sem_flag_unit.sv
`timescale 1ns/1ps
module sim_sem_flag_unit;
  localparam logic [15:0] ONES = 16'hFFFF;
  localparam logic [15:0] ZERO = 16'h0000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lSemEn = 0, lWrEn = 0, lWrBit = 0, rSemEn = 0, rWrEn = 0, rWrBit = 0;
  logic [2:0] lAddr = '0, rAddr = '0;
  logic [15:0] lRdData, rRdData;
  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sem_flag_unit u0 (
    .clk(clk), .rstN(rstN),
    .lSemEn(lSemEn), .lWrEn(lWrEn), .lWrBit(lWrBit), .lAddr(lAddr), .lRdData(lRdData),
    .rSemEn(rSemEn), .rWrEn(rWrEn), .rWrBit(rWrBit), .rAddr(rAddr), .rRdData(rRdData)
  );

  task automatic chk(string tag, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic idle();
    lSemEn = 0; lWrEn = 0; rSemEn = 0; rWrEn = 0;
  endtask

  // en: 0 none, 1 left only, 2 right only, 3 both
  task automatic wr(int en, logic [2:0] aL, logic bL, logic [2:0] aR, logic bR);
    lSemEn = en[0]; lWrEn = 1; lWrBit = bL; lAddr = aL;
    rSemEn = en[1]; rWrEn = 1; rWrBit = bR; rAddr = aR;
    tick(); idle();
  endtask

  task automatic rdChk(string tag, logic [2:0] aL, logic [15:0] eL, logic [2:0] aR, logic [15:0] eR);
    lSemEn = 1; lWrEn = 0; lAddr = aL;
    rSemEn = 1; rWrEn = 0; rAddr = aR;
    tick(); idle();
    chk({tag, " left"}, lRdData, eL);
    chk({tag, " right"}, rRdData, eR);
  endtask

  task automatic testReset();
    chk("R1 reset left", lRdData, ONES);
    chk("R1 reset right", rRdData, ONES);
    for (int a = 0; a < 8; a++) rdChk("R1 all free", 3'(a), ONES, 3'(a), ONES);
  endtask

  task automatic testClaim();
    wr(1, 3'd2, 1'b0, 3'd0, 1'b0);
    rdChk("R3/R4 left owns 2", 3'd2, ZERO, 3'd2, ONES);
    rdChk("R9 neighbours untouched", 3'd3, ONES, 3'd1, ONES);
  endtask

  task automatic testHandoff();
    wr(2, 3'd0, 1'b0, 3'd2, 1'b0);       // right queues on flag 2
    rdChk("R6 still left", 3'd2, ZERO, 3'd2, ONES);
    wr(1, 3'd2, 1'b1, 3'd0, 1'b0);       // left releases
    rdChk("R6 handed to right", 3'd2, ONES, 3'd2, ZERO);
  endtask

  task automatic testForeignRelease();
    wr(1, 3'd2, 1'b1, 3'd0, 1'b0);       // left is not owner
    rdChk("R7 foreign release ignored", 3'd2, ONES, 3'd2, ZERO);
    wr(2, 3'd0, 1'b0, 3'd2, 1'b1);       // owner releases
    rdChk("R7 owner release", 3'd2, ONES, 3'd2, ONES);
  endtask

  task automatic testTie();
    wr(3, 3'd5, 1'b0, 3'd5, 1'b0);
    rdChk("R5 tie left wins", 3'd5, ZERO, 3'd5, ONES);
    wr(1, 3'd5, 1'b1, 3'd0, 1'b0);
    rdChk("R5 right pending granted", 3'd5, ONES, 3'd5, ZERO);
    wr(2, 3'd0, 1'b0, 3'd5, 1'b1);
    rdChk("R2 both free again", 3'd5, ONES, 3'd5, ONES);
  endtask

  task automatic testCancel();
    wr(1, 3'd6, 1'b0, 3'd0, 1'b0);
    wr(2, 3'd0, 1'b0, 3'd6, 1'b0);       // right queues
    wr(2, 3'd0, 1'b0, 3'd6, 1'b1);       // right cancels
    wr(1, 3'd6, 1'b1, 3'd0, 1'b0);       // left releases
    rdChk("R7 cancelled request not granted", 3'd6, ONES, 3'd6, ONES);
  endtask

  task automatic testDisabled();
    lSemEn = 0; lWrEn = 1; lWrBit = 0; lAddr = 3'd7;
    rSemEn = 0; rWrEn = 1; rWrBit = 0; rAddr = 3'd7;
    tick(); idle();
    rdChk("R8 disabled write ignored", 3'd7, ONES, 3'd7, ONES);
    wr(1, 3'd0, 1'b0, 3'd0, 1'b0);
    rdChk("R8 setup", 3'd0, ZERO, 3'd0, ONES);
    lSemEn = 0; lWrEn = 0; lAddr = 3'd7;
    rSemEn = 0; rWrEn = 0; rAddr = 3'd7;
    tick(); tick();
    chk("R8 left read data held", lRdData, ZERO);
    chk("R8 right read data held", rRdData, ONES);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    tick();
    testReset();
    testClaim();
    testHandoff();
    testForeignRelease();
    testTie();
    testCancel();
    testDisabled();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule